// File: doc/BRIEF.md
# Quarter-Rate Down-Converter with Eight-Fold Decimation

This block takes a real, sampled intermediate-frequency stream and brings it to complex baseband at one eighth of the input rate. A fixed oscillator at minus one quarter of the sample rate shifts the band. Because the oscillator only ever takes the values 1, -j, -1 and +j, the mixer uses sign changes and zero insertion and needs no multipliers. Three identical decimate-by-two halfband filters then lower the rate. A tone sitting at +Fs/4 in the input comes out as DC.

The result leaves as beats that each carry two complex samples, so one output beat corresponds to sixteen accepted input samples. Internal arithmetic is 18 bits wide with round-half-up. The final samples are clipped to 16 bits, and any clipping anywhere in the path sets a flag that stays set until reset. A typical use is behind a converter running at 2 GSPS, where the beat rate becomes 125 MHz and about 200 MHz of the 250 MHz complex band is usable passband.

Top module: `ddc_fs4_dec8`

## Requirements
- R1: Accepted input samples, counted from 0 after reset, are multiplied in turn by 1, -j, -1, +j and repeat, then scaled by two. Sample n with phase 0 gives (I,Q)=(2x,0), phase 1 gives (0,-2x), phase 2 gives (-2x,0) and phase 3 gives (0,2x). The phase advances only when in_valid is high, and in_data is ignored while in_valid is low.
- R2: Each of the three halfband stages filters with the 11 symmetric taps 3, 0, -25, 0, 150, 256, 150, 0, -25, 0, 3. The result is rounded as (sum + 256) >> 9 with an arithmetic shift and then saturated to 18-bit signed. Only the 2nd, 4th, 6th, ... input of each stage after reset produces an output, computed over that input and the ten before it. History from before reset counts as zero.
- R3: The last stage output is saturated to 16-bit signed. overflow rises when any stage or the final clip saturates. It is visible no later than the beat that carries the clipped sample and stays high until reset.
- R4: The out_data word carries the earlier complex sample in bits [31:0] and the later one in bits [63:32]. Within each half, I sits in the low 16 bits and Q in the high 16 bits.
- R5: out_valid is a single-cycle pulse that comes once for every 16 accepted inputs. It is never high in two consecutive cycles, and it never comes before 16 inputs have been accepted since reset.
- R6: A synchronous, active-high reset clears the delay lines, the mixer phase, the decimation phases, the half-word selector and overflow. The first cycle after reset shows out_valid and overflow low, and the next stream is processed as if from power-up.
- R7: An input tone A, 0, -A, 0, ... (+Fs/4) settles to output samples with I equal to A and Q equal to 0 in both halves of every beat.
- R8: A constant input, which lies at -Fs/4 after mixing, settles to output components whose magnitude is at most 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed real input sample |
| out_valid | output | 1 | Output beat strobe |
| out_data | output | 64 | Two packed I/Q pairs, earlier pair in the low half |
| overflow | output | 1 | Sticky saturation flag |

## Verification
A slipped mixer phase swaps I and Q or flips their signs, which a tone at +Fs/4 exposes as a wrong or rotating DC value within one beat after the filters settle. A decimation phase that is off by one, or a stale tap, shifts every later sample by a bit-exact amount. The per-beat comparison catches this at the first beat whose window holds the fault. A wrong half-word selector reverses or drops samples and so shows up in the beat order straight away. Reset faults show up as leftover state in the first beats that follow a reset taken in the middle of a stream.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    localparam int IN_W     = 16;
    localparam int MID_W    = 18;
    localparam int ACC_W    = 32;
    localparam int HB_TAPS  = 11;
    localparam int HB_SHIFT = 9;
    localparam int NUM_HB   = 3;
    localparam int OUT_W    = 4 * IN_W;
    localparam int BEAT_IN  = 2 * (2 ** NUM_HB);

    localparam logic signed [ACC_W-1:0] HB_HALF = ACC_W'(1) <<< (HB_SHIFT - 1);
    localparam logic signed [ACC_W-1:0] MID_MAX = (ACC_W'(1) <<< (MID_W - 1)) - 1;
    localparam logic signed [ACC_W-1:0] MID_MIN = -MID_MAX - 1;
    localparam logic signed [ACC_W-1:0] OUT_MAX = (ACC_W'(1) <<< (IN_W - 1)) - 1;
    localparam logic signed [ACC_W-1:0] OUT_MIN = -OUT_MAX - 1;

    typedef enum logic [1:0] {
        PH_ONE     = 2'd0,
        PH_NEG_J   = 2'd1,
        PH_NEG_ONE = 2'd2,
        PH_POS_J   = 2'd3
    } mix_phase_t;

    typedef struct packed {
        logic signed [MID_W-1:0] re;
        logic signed [MID_W-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic                    hit;
        logic signed [ACC_W-1:0] val;
    } clip_t;

    // symmetric halfband taps, centre index HB_TAPS/2
    function automatic logic signed [ACC_W-1:0] hb_coef(input int k);
        int d;
        d = (k > HB_TAPS / 2) ? (k - HB_TAPS / 2) : (HB_TAPS / 2 - k);
        case (d)
            0:       return ACC_W'(256);
            1:       return ACC_W'(150);
            3:       return -ACC_W'(25);
            5:       return ACC_W'(3);
            default: return '0;
        endcase
    endfunction

    function automatic clip_t clip(input logic signed [ACC_W-1:0] v,
                                   input logic signed [ACC_W-1:0] hi,
                                   input logic signed [ACC_W-1:0] lo);
        clip_t c;
        c.hit = 1'b0;
        c.val = v;
        if (v > hi) begin
            c.hit = 1'b1;
            c.val = hi;
        end else if (v < lo) begin
            c.hit = 1'b1;
            c.val = lo;
        end
        return c;
    endfunction

endpackage

// File: rtl/ddc_fs4_mixer.sv
module ddc_fs4_mixer
    import ddc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_data,
    output logic                   out_valid,
    output cplx_t                  out_smp
);

    mix_phase_t              phase;
    logic signed [MID_W-1:0] pos;
    logic signed [MID_W-1:0] neg;
    cplx_t                   nxt;

    always_comb begin
        pos = {{(MID_W - IN_W){in_data[IN_W-1]}}, in_data} <<< 1;
        neg = -pos;
        nxt = '0;
        case (phase)
            PH_ONE:     nxt.re = pos;
            PH_NEG_J:   nxt.im = neg;
            PH_NEG_ONE: nxt.re = neg;
            default:    nxt.im = pos;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_ONE;
            out_valid <= 1'b0;
            out_smp   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                phase   <= mix_phase_t'(phase + 2'd1);
                out_smp <= nxt;
            end
        end
    end

endmodule

// File: rtl/ddc_hb_dec2.sv
module ddc_hb_dec2
    import ddc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  cplx_t in_smp,
    output logic  out_valid,
    output cplx_t out_smp,
    output logic  sat_evt
);

    cplx_t                   line [HB_TAPS-1];
    cplx_t                   win  [HB_TAPS];
    logic                    keep;
    logic signed [ACC_W-1:0] acc_re;
    logic signed [ACC_W-1:0] acc_im;
    clip_t                   c_re;
    clip_t                   c_im;

    always_comb begin
        win[0] = in_smp;
        for (int k = 1; k < HB_TAPS; k++) begin
            win[k] = line[k-1];
        end
    end

    always_comb begin
        acc_re = '0;
        acc_im = '0;
        for (int k = 0; k < HB_TAPS; k++) begin
            acc_re = acc_re + hb_coef(k) * ACC_W'(win[k].re);
            acc_im = acc_im + hb_coef(k) * ACC_W'(win[k].im);
        end
        c_re    = clip((acc_re + HB_HALF) >>> HB_SHIFT, MID_MAX, MID_MIN);
        c_im    = clip((acc_im + HB_HALF) >>> HB_SHIFT, MID_MAX, MID_MIN);
        sat_evt = in_valid && keep && (c_re.hit || c_im.hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < HB_TAPS - 1; k++) begin
                line[k] <= '0;
            end
            keep      <= 1'b0;
            out_valid <= 1'b0;
            out_smp   <= '0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                line[0] <= in_smp;
                for (int k = 1; k < HB_TAPS - 1; k++) begin
                    line[k] <= line[k-1];
                end
                keep <= ~keep;
                if (keep) begin
                    out_valid  <= 1'b1;
                    out_smp.re <= c_re.val[MID_W-1:0];
                    out_smp.im <= c_im.val[MID_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/ddc_pack2.sv
module ddc_pack2
    import ddc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  cplx_t            in_smp,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             sat_evt
);

    logic                  half;
    logic [2*IN_W-1:0]     held;
    clip_t                 c_re;
    clip_t                 c_im;
    logic  [2*IN_W-1:0]    pair;

    always_comb begin
        c_re    = clip(ACC_W'(in_smp.re), OUT_MAX, OUT_MIN);
        c_im    = clip(ACC_W'(in_smp.im), OUT_MAX, OUT_MIN);
        pair    = {c_im.val[IN_W-1:0], c_re.val[IN_W-1:0]};
        sat_evt = in_valid && (c_re.hit || c_im.hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            half      <= 1'b0;
            held      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                half <= ~half;
                if (!half) begin
                    held <= pair;
                end else begin
                    out_valid <= 1'b1;
                    out_data  <= {pair, held};
                end
            end
        end
    end

endmodule

// File: rtl/ddc_fs4_dec8.sv
module ddc_fs4_dec8
    import ddc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_data,
    output logic                   out_valid,
    output logic [OUT_W-1:0]       out_data,
    output logic                   overflow
);

    cplx_t              st_smp [NUM_HB+1];
    logic  [NUM_HB:0]   st_vld;
    logic  [NUM_HB-1:0] st_sat;
    logic               pack_sat;

    ddc_fs4_mixer u_mix (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (st_vld[0]),
        .out_smp   (st_smp[0])
    );

    for (genvar g = 0; g < NUM_HB; g++) begin : g_hb
        ddc_hb_dec2 u_hb (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (st_vld[g]),
            .in_smp    (st_smp[g]),
            .out_valid (st_vld[g+1]),
            .out_smp   (st_smp[g+1]),
            .sat_evt   (st_sat[g])
        );
    end

    ddc_pack2 u_pack (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (st_vld[NUM_HB]),
        .in_smp    (st_smp[NUM_HB]),
        .out_valid (out_valid),
        .out_data  (out_data),
        .sat_evt   (pack_sat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            overflow <= 1'b0;
        end else if ((|st_sat) || pack_sat) begin
            overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/ddc_fs4_dec8_chk.sv
module ddc_fs4_dec8_chk
    import ddc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data,
    input logic             overflow
);

    localparam int FILL_W = $clog2(BEAT_IN + 1);

    logic [FILL_W-1:0] fill;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
        end else if (in_valid && (fill != FILL_W'(BEAT_IN))) begin
            fill <= fill + 1'b1;
        end
    end

    // R5: a beat never occupies two cycles in a row
    p_beat_gap_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R5: no beat before sixteen accepted inputs
    p_min_fill_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (fill == FILL_W'(BEAT_IN)));

    // R3: the flag holds once raised
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R6: quiet outputs right after reset
    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !overflow));

    // R4: a delivered beat carries defined data
    p_known_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown(out_data));

endmodule

bind ddc_fs4_dec8 ddc_fs4_dec8_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .overflow  (overflow)
);

// File: tb/ddc_fs4_dec8_bench.sv
`timescale 1ns/1ps
module ddc_fs4_dec8_bench;

    typedef struct {
        logic [63:0] data;
        logic        ovf;
    } beat_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic               out_valid;
    logic [63:0]        out_data;
    logic               overflow;

    int n_chk  = 0;
    int n_fail = 0;
    int n_beat = 0;
    logic [63:0] last_data = '0;
    logic        prev_valid = 1'b0;
    beat_t       exp_q[$];

    // reference model state
    int m_phase;
    int m_hre [3][11];
    int m_him [3][11];
    bit m_keep [3];
    bit m_half;
    logic [31:0] m_held;
    bit m_ovf;
    logic [31:0] lfsr = 32'h1ace_b00c;

    always #2 clk = ~clk;

    ddc_fs4_dec8 u_ddc_fs4_dec8 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .overflow  (overflow)
    );

    function automatic int coef_of(int k);
        case (k)
            0, 10:   return 3;
            2, 8:    return -25;
            4, 6:    return 150;
            5:       return 256;
            default: return 0;
        endcase
    endfunction

    function automatic int sat_int(int v, int w);
        int hi = (1 << (w - 1)) - 1;
        int lo = -hi - 1;
        if (v > hi) begin m_ovf = 1'b1; return hi; end
        if (v < lo) begin m_ovf = 1'b1; return lo; end
        return v;
    endfunction

    task automatic model_reset();
        m_phase = 0;
        for (int s = 0; s < 3; s++) begin
            m_keep[s] = 1'b0;
            for (int k = 0; k < 11; k++) begin
                m_hre[s][k] = 0;
                m_him[s][k] = 0;
            end
        end
        m_half = 1'b0;
        m_held = '0;
        m_ovf  = 1'b0;
    endtask

    task automatic model_push(int x);
        int re, im, acc_re, acc_im;
        bit old;
        beat_t b;
        // R1: 1, -j, -1, +j, scaled by two
        case (m_phase)
            0:       begin re = 2 * x; im = 0;      end
            1:       begin re = 0;     im = -2 * x; end
            2:       begin re = -2 * x; im = 0;     end
            default: begin re = 0;     im = 2 * x;  end
        endcase
        m_phase = (m_phase + 1) % 4;
        // R2: three halfband stages
        for (int s = 0; s < 3; s++) begin
            for (int k = 10; k > 0; k--) begin
                m_hre[s][k] = m_hre[s][k-1];
                m_him[s][k] = m_him[s][k-1];
            end
            m_hre[s][0] = re;
            m_him[s][0] = im;
            old = m_keep[s];
            m_keep[s] = !old;
            if (!old) return;
            acc_re = 0;
            acc_im = 0;
            for (int k = 0; k < 11; k++) begin
                acc_re += coef_of(k) * m_hre[s][k];
                acc_im += coef_of(k) * m_him[s][k];
            end
            re = sat_int((acc_re + 256) >>> 9, 18);
            im = sat_int((acc_im + 256) >>> 9, 18);
        end
        // R3 final clip, R4 packing
        re = sat_int(re, 16);
        im = sat_int(im, 16);
        if (!m_half) begin
            m_held = {16'(im), 16'(re)};
            m_half = 1'b1;
        end else begin
            b.data = {16'(im), 16'(re), m_held};
            b.ovf  = m_ovf;
            exp_q.push_back(b);
            m_half = 1'b0;
        end
    endtask

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic put(bit v, int x);
        @(negedge clk);
        in_valid <= v;
        in_data  <= 16'(x);
        if (v) model_push(x);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) put(1'b0, 16'h5a5a - i);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst      <= 1'b1;
        in_valid <= 1'b0;
        repeat (2) @(negedge clk);
        rst <= 1'b0;
        model_reset();
        exp_q.delete();
        @(negedge clk);
        check("R6 out_valid after reset", 64'(out_valid), 64'd0);
        check("R6 overflow after reset", 64'(overflow), 64'd0);
    endtask

    function automatic int rnd_small();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return $signed(lfsr[15:0]) >>> 2;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_valid && out_valid) begin
                n_chk++;
                n_fail++;
                $display("FAIL R5: actual out_valid high twice expected single pulse");
            end
            if (out_valid) begin
                n_beat++;
                last_data = out_data;
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL R5: actual extra beat %h expected none", out_data);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    check("R2 R4 beat data", out_data, e.data);
                    check("R3 overflow at beat", 64'(overflow), 64'(e.ovf));
                end
            end
        end
        prev_valid = out_valid && !rst;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int b0;
        int v;
        model_reset();
        do_reset();

        // R7: +Fs/4 tone lands at DC
        b0 = n_beat;
        for (int i = 0; i < 256; i++) begin
            case (i % 4)
                0:       put(1'b1, 12000);
                2:       put(1'b1, -12000);
                default: put(1'b1, 0);
            endcase
        end
        idle(20);
        check("R5 beats per 256 inputs", 64'(n_beat - b0), 64'd16);
        check("R5 all expected beats seen", 64'(exp_q.size()), 64'd0);
        check("R7 settled DC", last_data, {16'd0, 16'd12000, 16'd0, 16'd12000});

        // R1: gapped stream, junk on invalid cycles
        for (int i = 0; i < 240; i++) begin
            put(1'b1, rnd_small());
            if (i % 3 == 1) put(1'b0, -32768);
            if (i % 5 == 2) idle(2);
        end
        idle(20);
        check("R1 gapped stream drained", 64'(exp_q.size()), 64'd0);

        // R8: constant input is rejected
        for (int i = 0; i < 256; i++) put(1'b1, 10000);
        idle(20);
        n_chk++;
        for (int h = 0; h < 4; h++) begin
            v = $signed(last_data[16*h +: 16]);
            if (v > 4 || v < -4) begin
                n_fail++;
                $display("FAIL R8: actual field %0d = %0d expected |x| <= 4", h, v);
                break;
            end
        end
        check("R3 no overflow at moderate levels", 64'(overflow), 64'd0);

        // R6: reset in mid-stream, odd phases left behind
        for (int i = 0; i < 37; i++) put(1'b1, rnd_small());
        idle(20);
        do_reset();
        b0 = n_beat;
        for (int i = 0; i < 160; i++) put(1'b1, rnd_small());
        idle(20);
        check("R6 beats after reset", 64'(n_beat - b0), 64'd10);
        check("R6 drained after reset", 64'(exp_q.size()), 64'd0);

        // R3: full-scale step overshoots and clips
        for (int i = 0; i < 64; i++) put(1'b1, 0);
        idle(12);
        check("R3 overflow clear before step", 64'(overflow), 64'd0);
        for (int i = 0; i < 256; i++) begin
            case (i % 4)
                0:       put(1'b1, 32767);
                2:       put(1'b1, -32767);
                default: put(1'b1, 0);
            endcase
        end
        idle(20);
        check("R3 overflow raised", 64'(overflow), 64'd1);
        for (int i = 0; i < 64; i++) put(1'b1, 0);
        idle(20);
        check("R3 overflow sticky", 64'(overflow), 64'd1);
        do_reset();
        idle(4);
        check("R6 overflow cleared by reset", 64'(overflow), 64'd0);

        finish_run();
    end

endmodule